// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives configuration writes over a three-line serial link (serial clock, serial data and an active-low load line) and holds the result in a small bank of 12-bit registers. A frame opens when the load line falls. It carries a register address, one reserved bit and then one or more 12-bit data words. Each word lands in a shadow register, and the word that follows goes to the next address up. The load line rising ends the frame and copies every shadow register into the active bank in one step, so downstream logic never sees a half-applied set of settings.

All serial lines are sampled in the core clock domain. After reset, a startup counter keeps the port deaf for a programmable number of core cycles. Register 0 holds a self-clearing software reset and a power-mode field, and the power mode is brought out on its own port. The clamp-level register (index 2) comes out of every reset at 128, and the other registers come out at zero.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, every active register reads 0 except register 2, which reads 128, and `power_mode_o` reads 0. Register n appears on `cfg_o[12n+11:12n]`.
- R2: On rising serial-clock edges while the load line is low, the frame shifts in three address bits (least significant first), one reserved bit, and then 12-bit words (least significant first).
- R3: A completed word does not appear on `cfg_o` before the load line rises. All words of one frame appear together once it has risen.
- R4: Within one frame, word k goes to address (start + k) modulo 8.
- R5: Words whose address is 4 or higher are discarded, but the address still advances, so a frame that starts at 7 writes its second word to register 0.
- R6: If the last word of a frame is incomplete when the load line rises, that word's target register keeps its old value. Complete words earlier in the frame are still applied.
- R7: A frame whose reserved bit is 1 changes no register.
- R8: Committing a value with register 0 bit 0 set returns every register, including register 0, to its reset value.
- R9: `power_mode_o` equals bits 2:1 of active register 0 (0 normal, 1 standby, 2 shutdown).
- R10: For STARTUP_CYCLES core cycles after reset, frames are ignored, and so is any frame whose load line fell inside that window, even if it ends after the window.
- R11: Serial-clock edges while the load line is high shift nothing in and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data |
| ser_load_n_i | input | 1 | Load line: low frames a transfer, rising edge commits |
| cfg_o | output | NUM_REGS*12 | Active register bank, register n at bits 12n+11:12n |
| power_mode_o | output | 2 | Power mode taken from register 0 bits 2:1 |

## Verification
The hardest case to reach is a frame whose load line falls during the startup lockout but rises after it. The commit edge then arrives while the port is live, and only the missing frame start keeps it out. The stimulus places one frame entirely inside the lockout window. It then opens a second frame inside the window and holds the load line low until a cycle counter in the stimulus has passed STARTUP_CYCLES. Address wrap-around is reached by starting a two-word frame at address 7, and a partial trailing word by adding five extra bits before the load line rises.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TBIT,
    ST_DATA,
    ST_DROP
  } frame_st_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sync_o;
  end

  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/scp_startup.sv
module scp_startup #(
  parameter int CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!rdy_q) begin
      if (cnt_q == CW'(CYCLES - 1)) rdy_d = 1'b1;
      else                          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;

  // R10
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
  import scp_pkg::*;
#(
  parameter int DW     = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic              sck_rise_i,
  input  logic              dat_i,
  input  logic              load_fall_i,
  input  logic              load_rise_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o
);
  localparam int CNT_W = $clog2(DW + 1);

  frame_st_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     word_q, word_d;
  logic              wr_en_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [DW-1:0]     wr_data_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    word_d    = word_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_o;
    wr_data_d = wr_data_o;
    if (load_rise_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load_fall_i && ready_i) begin
          st_d  = ST_ADDR;
          cnt_d = '0;
        end
        ST_ADDR: if (sck_rise_i) begin
          addr_d = {dat_i, addr_q[ADDR_W-1:1]};
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            st_d  = ST_TBIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TBIT: if (sck_rise_i) begin
          st_d  = dat_i ? ST_DROP : ST_DATA;
          cnt_d = '0;
        end
        ST_DATA: if (sck_rise_i) begin
          word_d = {dat_i, word_q[DW-1:1]};
          if (cnt_q == CNT_W'(DW - 1)) begin
            wr_en_d   = 1'b1;
            wr_addr_d = addr_q;
            wr_data_d = word_d;
            addr_d    = addr_q + 1'b1;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DROP: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      word_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      addr_q    <= addr_d;
      word_q    <= word_d;
      wr_en_o   <= wr_en_d;
      wr_addr_o <= wr_addr_d;
      wr_data_o <= wr_data_d;
    end
  end

  // R10
  wr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ready_i);
  // R2
  load_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise_i |=> (st_q == ST_IDLE));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (cnt_q < CNT_W'(DW)));
endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int DW        = 12,
  parameter int ADDR_W    = 3,
  parameter int NUM_REGS  = 4,
  parameter int CLAMP_IDX = 2,
  parameter int CLAMP_DEF = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic                          commit_i,
  output logic [NUM_REGS-1:0][DW-1:0]   active_o
);
  logic [NUM_REGS-1:0][DW-1:0] sh_q, sh_d, ac_d, eff, dflt;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      dflt[i] = (i == CLAMP_IDX) ? DW'(CLAMP_DEF) : '0;
      eff[i]  = (wr_en_i && wr_addr_i == ADDR_W'(i)) ? wr_data_i : sh_q[i];
    end
  end

  always_comb begin
    sh_d = eff;
    ac_d = active_o;
    if (commit_i) begin
      if (eff[0][0]) begin
        sh_d = dflt;
        ac_d = dflt;
      end else begin
        ac_d = eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= dflt;
      active_o <= dflt;
    end else begin
      sh_q     <= sh_d;
      active_o <= ac_d;
    end
  end

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(active_o));
  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !wr_en_i) |=> $stable(sh_q));
  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && eff[0][0]) |=> (active_o == dflt));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int DW             = 12,
  parameter int ADDR_W         = 3,
  parameter int NUM_REGS       = 4,
  parameter int CLAMP_IDX      = 2,
  parameter int CLAMP_DEF      = 128,
  parameter int SYNC_STAGES    = 2,
  parameter int STARTUP_CYCLES = 25000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_load_n_i,
  output logic [NUM_REGS*DW-1:0] cfg_o,
  output logic [1:0]             power_mode_o
);
  localparam int SCK = 0;
  localparam int DAT = 1;
  localparam int LDN = 2;

  logic [2:0]                  s_lvl, s_rise, s_fall;
  logic                        ready;
  logic                        wr_en;
  logic [ADDR_W-1:0]           wr_addr;
  logic [DW-1:0]               wr_data;
  logic                        commit;
  logic [NUM_REGS-1:0][DW-1:0] active;

  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_load_n_i, ser_dat_i, ser_clk_i}),
    .sync_o  (s_lvl),
    .rise_o  (s_rise),
    .fall_o  (s_fall)
  );

  scp_startup #(.CYCLES(STARTUP_CYCLES)) u_startup (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready)
  );

  scp_shifter #(.DW(DW), .ADDR_W(ADDR_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready),
    .sck_rise_i  (s_rise[SCK]),
    .dat_i       (s_lvl[DAT]),
    .load_fall_i (s_fall[LDN]),
    .load_rise_i (s_rise[LDN]),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  assign commit = s_rise[LDN] & ready;

  scp_bank #(
    .DW(DW), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .CLAMP_IDX(CLAMP_IDX), .CLAMP_DEF(CLAMP_DEF)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .active_o  (active)
  );

  assign cfg_o        = active;
  assign power_mode_o = active[0][2:1];

  // R9
  pmode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_mode_o == cfg_o[2:1]);
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int SH         = 4;
  localparam int STARTUP    = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_dat, ser_load_n;
  logic [47:0] cfg;
  logic [1:0]  pmode;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  int          q_idx[$];
  logic [11:0] q_val[$];
  string       q_tag[$];
  logic [11:0] m[4];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  serial_cfg_port #(.STARTUP_CYCLES(STARTUP)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk_i    (ser_clk),
    .ser_dat_i    (ser_dat),
    .ser_load_n_i (ser_load_n),
    .cfg_o        (cfg),
    .power_mode_o (pmode)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (q_idx.size() > 0) begin
        int          idx;
        logic [11:0] exp, act;
        string       tg;
        idx = q_idx.pop_front();
        exp = q_val.pop_front();
        tg  = q_tag.pop_front();
        act = (idx < 4) ? cfg[idx*12 +: 12] : {10'b0, pmode};
        vectors++;
        if (act !== exp) begin
          fails++;
          $display("FAIL %s item %0d: actual %h expected %h", tg, idx, act, exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q_idx.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      q_idx.push_back(i); q_val.push_back(m[i]); q_tag.push_back(tag);
    end
    q_idx.push_back(4); q_val.push_back({10'b0, m[0][2:1]}); q_tag.push_back(tag);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    idle(SH);
    ser_clk = 1'b1;
    idle(SH);
    ser_clk = 1'b0;
  endtask

  task automatic frame(input int a, input bit tb, input int nw,
                       input logic [11:0] w0, input logic [11:0] w1,
                       input logic [11:0] w2, input int part, input bit pre,
                       input int hold, input bit live, input string tag);
    logic [11:0] ws[3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    ser_load_n = 1'b0;
    idle(SH*2);
    for (int i = 0; i < 3; i++) send_bit(a[i]);
    send_bit(tb);
    for (int k = 0; k < nw; k++)
      for (int i = 0; i < 12; i++) send_bit(ws[k][i]);
    for (int i = 0; i < part; i++) send_bit(1'b1);
    idle(SH*2);
    while (cyc < hold) @(posedge clk);
    if (pre) begin
      check_all("R3 before load rise");
      drain();
    end
    @(negedge clk);
    ser_load_n = 1'b1;
    idle(16);
    if (live && !tb) begin
      for (int k = 0; k < nw; k++) begin
        int ad;
        ad = (a + k) % 8;
        if (ad < 4) m[ad] = ws[k];
      end
      if (m[0][0]) begin
        m[0] = 12'd0; m[1] = 12'd0; m[2] = 12'd128; m[3] = 12'd0;
      end
    end
    check_all(tag);
    drain();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    ser_clk = 1'b0; ser_dat = 1'b0; ser_load_n = 1'b1;
    m[0] = 12'd0; m[1] = 12'd0; m[2] = 12'd128; m[3] = 12'd0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    check_all("R1 reset");
    drain();
    // R10 frame wholly inside lockout
    frame(1, 0, 1, 12'hABC, 12'h0, 12'h0, 0, 0, 0, 0, "R10 inside lockout");
    // R10 frame opened in lockout, closed after it
    frame(1, 0, 1, 12'h123, 12'h0, 12'h0, 0, 0, STARTUP + 40, 0, "R10 straddles lockout");
    // R2 single word with R3 hold check
    frame(1, 0, 1, 12'h5A3, 12'h0, 12'h0, 0, 1, 0, 1, "R2 single word");
    // R4 auto-increment over three words, R3 together
    frame(1, 0, 3, 12'h111, 12'h222, 12'h333, 0, 1, 0, 1, "R4 auto increment");
    // R5 word past the bank is dropped
    frame(3, 0, 2, 12'h0F0, 12'hFFE, 12'h0, 0, 0, 0, 1, "R5 drop above bank");
    // R5 wrap from 7 to 0, R9 power mode shutdown
    frame(7, 0, 2, 12'h7FE, 12'h004, 12'h0, 0, 0, 0, 1, "R5 R9 wrap to reg0");
    // R9 standby
    frame(0, 0, 1, 12'h002, 12'h0, 12'h0, 0, 0, 0, 1, "R9 standby");
    // R6 partial trailing word
    frame(2, 0, 1, 12'h0C3, 12'h0, 12'h0, 5, 0, 0, 1, "R6 partial word");
    // R7 reserved bit set
    frame(1, 1, 2, 12'h999, 12'h888, 12'h0, 0, 0, 0, 1, "R7 reserved bit");
    // R11 stray serial clocks while load high
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    frame(1, 0, 1, 12'h246, 12'h0, 12'h0, 0, 0, 0, 1, "R11 stray clocks");
    // R8 soft reset
    frame(0, 0, 1, 12'h003, 12'h0, 12'h0, 0, 0, 0, 1, "R8 soft reset");
    // R2 after soft reset, port still writable
    frame(3, 0, 1, 12'hC5A, 12'h0, 12'h0, 0, 0, 0, 1, "R2 after soft reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule